// File: doc/BRIEF.md
# Random Generator Control Unit

This block is the register front end of a random-number generator. Software talks to it over a plain 32-bit register bus: an address, a write strobe, write data and combinational read data. It writes a command word to start either a reseed or the generation of a fresh value. It polls two busy flags or waits for an interrupt. It then reads back the value as four or eight 32-bit words. A stand-in core models the generator. The core is a 32-bit Galois LFSR that is loaded from an `entropy_i` input at the end of a fixed-length seeding phase. It shifts one word per cycle into the output bank while generating.

The control path is a three-state machine:

- **IDLE** accepts work. Transitions from IDLE:
  - **T_AUTO** enters SEED when an automatic reseed is pending. It wins over any host command in the same cycle.
  - **T_CMD_SEED** enters SEED on a reseed command.
  - **T_CMD_GEN** enters GEN on a generate command, but only once the core has been seeded.
- **SEED** lasts `SEED_CYCLES` cycles. It leaves through **T_SEED_DONE**, which loads the LFSR, sets the seeded flag, raises the seeding-done event and reloads both automatic reseed counters.
- **GEN** lasts four or eight cycles, one per output word. It leaves through **T_GEN_DONE**, which raises the output-ready event.

Events are held in sticky, write-one-to-clear pending bits. A global enable gates them onto a single interrupt line. Two independent triggers request an automatic reseed. One is a counter of accepted generate commands. The other is an age timer that counts prescaled ticks. A zero reload value switches either trigger off.

Top module: `rng_ctl_unit`

## Requirements
- R1: After reset the status register (0x04) reads 0x0000_0008, the mode register (0x08) reads 0x0000_0008, the interrupt enable (0x10) and interrupt pending (0x14) registers read 0, and `irq_o` is low.
- R2: Writing 2 to the command register (0x00) while idle sets status bit 31 for exactly `SEED_CYCLES` cycles. After that, status bit 9 (seeded) is set and pending bit 1 (seeding done) is set.
- R3: Writing 1 to the command register while idle and seeded sets status bit 30 for 8 cycles in wide mode or 4 cycles in narrow mode. After that, pending bit 0 (output ready) is set, and a new value that differs from the previous one is readable at 0x20 + 4*i.
- R4: Mode bit 3 set selects wide output, with eight valid words. Clear selects narrow output: words 0 to 3 are valid and words 4 to 7 read 0. Status bit 3 mirrors mode bit 3.
- R5: A command written while status bit 30 or bit 31 is set is ignored, and so is a mode write. No status or pending change results from either.
- R6: A generate command before the first seeding completes is ignored: status stays idle and pending bit 0 stays clear.
- R7: Writing 1 to a pending bit (0, 1 or 4) at 0x14 clears it. Writing 0 leaves it unchanged.
- R8: `irq_o` is high exactly when enable bit 31 is set and some pending bit k (k = 0, 1, 4) has enable bit k set.
- R9: If the LFSR state becomes all zeros, which happens when seeding loads zero entropy, pending bit 4 (lockup) is set. Output words generated from that state read 0.
- R10: A nonzero value N written to 0x60 loads a counter that drops by one on each accepted generate command. The cycle after the generation that brings it to zero ends, an automatic reseed starts.
- R11: A nonzero value N written to 0x64 loads a timer that drops by one every `TICK_CYCLES` clock cycles. When it reaches zero an automatic reseed starts. Any completed reseed reloads both the counter and the timer from their registers.
- R12: A reload value of 0 in 0x60 or 0x64 disables that trigger, so no automatic reseed follows from it.
- R13: Writing 0 or any code other than 1 or 2 to the command register has no effect, and the command register reads 0. Only bit 3 of the mode register is kept. The enable register keeps bits 0, 1, 4 and 31. Register 0x0C keeps bits 2, 8 and 23:16 and has no other effect. The reload registers keep their low 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Byte address of the register access |
| we_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | 32 | Write data |
| entropy_i | input | 32 | Seed material, sampled on the last seeding cycle |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The assertions take for granted that every write is a single-cycle strobe on a word-aligned address. They also assume that `entropy_i` holds steady across each seeding phase, so the LFSR contents follow from the value present at the end of that phase. The stimulus writes only through one-cycle strobes issued on the falling clock edge. It changes `entropy_i` only while the machine is idle. It also turns the age timer off again right after its own test, so that no automatic reseed overlaps a directed check.

// File: rtl/rngc_pkg.sv
package rngc_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEED = 2'd1,
        ST_GEN  = 2'd2
    } rngc_state_e;

    // register byte offsets
    localparam logic [7:0] OFF_CMD    = 8'h00;
    localparam logic [7:0] OFF_STAT   = 8'h04;
    localparam logic [7:0] OFF_MODE   = 8'h08;
    localparam logic [7:0] OFF_AUX    = 8'h0C;
    localparam logic [7:0] OFF_IEN    = 8'h10;
    localparam logic [7:0] OFF_IPEND  = 8'h14;
    localparam logic [7:0] OFF_WORD0  = 8'h20;
    localparam logic [7:0] OFF_REQRLD = 8'h60;
    localparam logic [7:0] OFF_AGERLD = 8'h64;

    // command codes
    localparam logic [31:0] CMD_GENERATE = 32'd1;
    localparam logic [31:0] CMD_RESEED   = 32'd2;

    // status and mode bit positions
    localparam int STB_WIDE    = 3;
    localparam int STB_SEEDED  = 9;
    localparam int STB_GENBUSY = 30;
    localparam int STB_SEEDBSY = 31;
    localparam int MDB_WIDE    = 3;
    localparam int IEN_GLOBAL  = 31;

    // event indices (internal order) and their bit positions in the register
    localparam int NUM_EV  = 3;
    localparam int EV_RDY  = 0;
    localparam int EV_SEED = 1;
    localparam int EV_LOCK = 2;

    localparam logic [31:0] AUX_KEEP = 32'h00FF_0104;
    localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

    function automatic int ev_pos(input int k);
        return (k == EV_LOCK) ? 4 : k;
    endfunction

endpackage

// File: rtl/rngc_engine.sv
module rngc_engine
    import rngc_pkg::*;
#(
    parameter int SEED_CYCLES = 16,
    parameter int MAX_WORDS   = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           gen_cmd_i,
    input  logic                           seed_cmd_i,
    input  logic                           auto_seed_i,
    input  logic                           wide_i,
    input  logic [DATA_W-1:0]              entropy_i,
    output logic                           gen_busy_o,
    output logic                           seed_busy_o,
    output logic                           seeded_o,
    output logic                           gen_accept_o,
    output logic                           rdy_ev_o,
    output logic                           seed_ev_o,
    output logic                           lock_ev_o,
    output logic [MAX_WORDS-1:0][DATA_W-1:0] words_o
);

    localparam int HALF      = MAX_WORDS / 2;
    localparam int PHASE_MAX = (SEED_CYCLES > MAX_WORDS) ? SEED_CYCLES : MAX_WORDS;
    localparam int PH_W      = $clog2(PHASE_MAX + 1);

    rngc_state_e       state_q, state_d;
    logic [PH_W-1:0]   phase_q;
    logic [DATA_W-1:0] lfsr_q;
    logic [DATA_W-1:0] lfsr_step;
    logic [DATA_W-1:0] words_q [MAX_WORDS];
    logic              seeded_q;
    logic              phase_end;
    logic              start_seed;
    logic              start_gen;

    assign phase_end  = (phase_q == '0);
    assign start_seed = (state_q == ST_IDLE) && (auto_seed_i || seed_cmd_i);
    assign start_gen  = (state_q == ST_IDLE) && !auto_seed_i && !seed_cmd_i
                        && gen_cmd_i && seeded_q;
    assign lfsr_step  = {1'b0, lfsr_q[DATA_W-1:1]} ^ ({DATA_W{lfsr_q[0]}} & LFSR_TAPS);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_seed)     state_d = ST_SEED;   // T_AUTO / T_CMD_SEED
                else if (start_gen) state_d = ST_GEN;    // T_CMD_GEN
            end
            ST_SEED: if (phase_end) state_d = ST_IDLE;   // T_SEED_DONE
            ST_GEN:  if (phase_end) state_d = ST_IDLE;   // T_GEN_DONE
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // phase counter, LFSR and seeded flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= '0;
            lfsr_q   <= '0;
            seeded_q <= 1'b0;
        end else begin
            if (start_seed)
                phase_q <= PH_W'(SEED_CYCLES - 1);
            else if (start_gen)
                phase_q <= wide_i ? PH_W'(MAX_WORDS - 1) : PH_W'(HALF - 1);
            else if (state_q != ST_IDLE && !phase_end)
                phase_q <= phase_q - 1'b1;

            if (state_q == ST_SEED && phase_end) begin
                lfsr_q   <= entropy_i;
                seeded_q <= 1'b1;
            end else if (state_q == ST_GEN) begin
                lfsr_q   <= lfsr_step;
            end
        end
    end

    // output word bank: one word shifted in per generating cycle
    for (genvar i = 0; i < MAX_WORDS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words_q[i] <= '0;
            end else if (state_q == ST_GEN) begin
                if (i == 0) words_q[i] <= lfsr_q;
                else        words_q[i] <= words_q[(i > 0) ? i - 1 : 0];
            end
        end
        assign words_o[i] = words_q[i];
    end

    // outputs
    always_comb begin
        gen_busy_o   = (state_q == ST_GEN);
        seed_busy_o  = (state_q == ST_SEED);
        seeded_o     = seeded_q;
        gen_accept_o = start_gen;
        rdy_ev_o     = (state_q == ST_GEN) && phase_end;
        seed_ev_o    = (state_q == ST_SEED) && phase_end;
        lock_ev_o    = (seed_ev_o && (entropy_i == '0))
                     || ((state_q == ST_GEN) && (lfsr_step == '0));
    end

    AST_GEN_NEEDS_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GEN) |-> seeded_q);                                   // R6
    AST_SEED_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        seed_ev_o |=> seeded_q);                                             // R2
    AST_BUSY_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !phase_end) |=> (state_q == $past(state_q))); // R5

endmodule

// File: rtl/rngc_autoseed.sv
module rngc_autoseed #(
    parameter int CNT_W       = 16,
    parameter int TICK_CYCLES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] req_reload_i,
    input  logic [CNT_W-1:0] age_reload_i,
    input  logic [1:0]       load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             seed_done_i,
    input  logic             gen_accept_i,
    output logic             auto_seed_o
);

    localparam int PRE_W = $clog2(TICK_CYCLES + 1);

    logic [PRE_W-1:0] pre_q;
    logic             tick;
    logic [1:0]       pend;
    logic [1:0]       dec;
    logic [CNT_W-1:0] reload [2];

    assign tick      = (pre_q == PRE_W'(TICK_CYCLES - 1));
    assign dec       = {tick, gen_accept_i};
    assign reload[0] = req_reload_i;
    assign reload[1] = age_reload_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end

    // channel 0 counts accepted requests, channel 1 counts timer ticks
    for (genvar k = 0; k < 2; k++) begin : g_chan
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      cnt_q <= '0;
            else if (load_i[k])              cnt_q <= load_val_i;
            else if (seed_done_i)            cnt_q <= reload[k];
            else if (dec[k] && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
        end

        assign pend[k] = (reload[k] != '0) && (cnt_q == '0);

        AST_COUNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q == '0 && !load_i[k] && !seed_done_i) |=> (cnt_q == '0)); // R12
    end

    assign auto_seed_o = |pend;

endmodule

// File: rtl/rngc_irq.sv
module rngc_irq
    import rngc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic              clr_en_i,
    input  logic [NUM_EV-1:0] clr_mask_i,
    input  logic [NUM_EV-1:0] ev_en_i,
    input  logic              glb_en_i,
    output logic [NUM_EV-1:0] pend_o,
    output logic              irq_o
);

    for (genvar k = 0; k < NUM_EV; k++) begin : g_ev
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          bit_q <= 1'b0;
            else if (ev_i[k])                    bit_q <= 1'b1;
            else if (clr_en_i && clr_mask_i[k])  bit_q <= 1'b0;
        end
        assign pend_o[k] = bit_q;
    end

    assign irq_o = glb_en_i && |(pend_o & ev_en_i);

    AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> glb_en_i);                                                 // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && clr_mask_i[EV_RDY] && !ev_i[EV_RDY]) |=> !pend_o[EV_RDY]); // R7
    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i[EV_SEED] |=> pend_o[EV_SEED]);                                  // R2

endmodule

// File: rtl/rng_ctl_unit.sv
module rng_ctl_unit
    import rngc_pkg::*;
#(
    parameter int SEED_CYCLES = 16,
    parameter int TICK_CYCLES = 1024,
    parameter int MAX_WORDS   = 8,
    parameter int CNT_W       = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  addr_i,
    input  logic        we_i,
    input  logic [31:0] wdata_i,
    input  logic [31:0] entropy_i,
    output logic [31:0] rdata_o,
    output logic        irq_o
);

    localparam int HALF  = MAX_WORDS / 2;
    localparam int IDX_W = $clog2(MAX_WORDS);
    localparam logic [7:0] WORD_END = OFF_WORD0 + 8'(4 * MAX_WORDS);

    logic              mode_wide_q;
    logic [31:0]       aux_q;
    logic [NUM_EV-1:0] ev_en_q;
    logic              glb_en_q;
    logic [CNT_W-1:0]  req_rld_q;
    logic [CNT_W-1:0]  age_rld_q;

    logic gen_busy, seed_busy, seeded, gen_accept;
    logic rdy_ev, seed_ev, lock_ev, auto_seed;
    logic [MAX_WORDS-1:0][DATA_W-1:0] words;
    logic [NUM_EV-1:0] pend;
    logic [NUM_EV-1:0] ev_vec;
    logic [NUM_EV-1:0] clr_mask;
    logic [NUM_EV-1:0] ien_mask;
    logic [1:0]        cnt_load;

    logic wr_cmd, wr_mode, wr_aux, wr_ien, wr_ipend, wr_req, wr_age;
    logic [7:0]       word_off;
    logic [IDX_W-1:0] word_idx;
    logic             in_words;

    assign wr_cmd   = we_i && (addr_i == OFF_CMD);
    assign wr_mode  = we_i && (addr_i == OFF_MODE);
    assign wr_aux   = we_i && (addr_i == OFF_AUX);
    assign wr_ien   = we_i && (addr_i == OFF_IEN);
    assign wr_ipend = we_i && (addr_i == OFF_IPEND);
    assign wr_req   = we_i && (addr_i == OFF_REQRLD);
    assign wr_age   = we_i && (addr_i == OFF_AGERLD);
    assign cnt_load = {wr_age, wr_req};

    always_comb begin
        for (int k = 0; k < NUM_EV; k++) begin
            clr_mask[k] = wdata_i[ev_pos(k)];
            ien_mask[k] = wdata_i[ev_pos(k)];
        end
    end

    assign ev_vec[EV_RDY]  = rdy_ev;
    assign ev_vec[EV_SEED] = seed_ev;
    assign ev_vec[EV_LOCK] = lock_ev;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_wide_q <= 1'b1;
            aux_q       <= '0;
            ev_en_q     <= '0;
            glb_en_q    <= 1'b0;
            req_rld_q   <= '0;
            age_rld_q   <= '0;
        end else begin
            if (wr_mode && !gen_busy && !seed_busy) mode_wide_q <= wdata_i[MDB_WIDE];
            if (wr_aux) aux_q <= wdata_i & AUX_KEEP;
            if (wr_ien) begin
                ev_en_q  <= ien_mask;
                glb_en_q <= wdata_i[IEN_GLOBAL];
            end
            if (wr_req) req_rld_q <= wdata_i[CNT_W-1:0];
            if (wr_age) age_rld_q <= wdata_i[CNT_W-1:0];
        end
    end

    rngc_engine #(
        .SEED_CYCLES (SEED_CYCLES),
        .MAX_WORDS   (MAX_WORDS)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .gen_cmd_i    (wr_cmd && (wdata_i == CMD_GENERATE)),
        .seed_cmd_i   (wr_cmd && (wdata_i == CMD_RESEED)),
        .auto_seed_i  (auto_seed),
        .wide_i       (mode_wide_q),
        .entropy_i    (entropy_i),
        .gen_busy_o   (gen_busy),
        .seed_busy_o  (seed_busy),
        .seeded_o     (seeded),
        .gen_accept_o (gen_accept),
        .rdy_ev_o     (rdy_ev),
        .seed_ev_o    (seed_ev),
        .lock_ev_o    (lock_ev),
        .words_o      (words)
    );

    rngc_autoseed #(
        .CNT_W       (CNT_W),
        .TICK_CYCLES (TICK_CYCLES)
    ) u_autoseed (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_reload_i (req_rld_q),
        .age_reload_i (age_rld_q),
        .load_i       (cnt_load),
        .load_val_i   (wdata_i[CNT_W-1:0]),
        .seed_done_i  (seed_ev),
        .gen_accept_i (gen_accept),
        .auto_seed_o  (auto_seed)
    );

    rngc_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev_vec),
        .clr_en_i   (wr_ipend),
        .clr_mask_i (clr_mask),
        .ev_en_i    (ev_en_q),
        .glb_en_i   (glb_en_q),
        .pend_o     (pend),
        .irq_o      (irq_o)
    );

    // read path
    assign word_off = addr_i - OFF_WORD0;
    assign word_idx = word_off[IDX_W+1:2];
    assign in_words = (addr_i >= OFF_WORD0) && (addr_i < WORD_END) && (addr_i[1:0] == 2'b00);

    always_comb begin
        rdata_o = '0;
        if (in_words) begin
            if (mode_wide_q || (int'(word_idx) < HALF)) rdata_o = words[word_idx];
        end else begin
            unique case (addr_i)
                OFF_STAT: begin
                    rdata_o[STB_WIDE]    = mode_wide_q;
                    rdata_o[STB_SEEDED]  = seeded;
                    rdata_o[STB_GENBUSY] = gen_busy;
                    rdata_o[STB_SEEDBSY] = seed_busy;
                end
                OFF_MODE: rdata_o[MDB_WIDE] = mode_wide_q;
                OFF_AUX:  rdata_o = aux_q;
                OFF_IEN: begin
                    for (int k = 0; k < NUM_EV; k++) rdata_o[ev_pos(k)] = ev_en_q[k];
                    rdata_o[IEN_GLOBAL] = glb_en_q;
                end
                OFF_IPEND: begin
                    for (int k = 0; k < NUM_EV; k++) rdata_o[ev_pos(k)] = pend[k];
                end
                OFF_REQRLD: rdata_o[CNT_W-1:0] = req_rld_q;
                OFF_AGERLD: rdata_o[CNT_W-1:0] = age_rld_q;
                default:    rdata_o = '0;
            endcase
        end
    end

    AST_MODE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_busy || seed_busy) |=> (mode_wide_q == $past(mode_wide_q)));   // R5
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_wide_q && in_words && int'(word_idx) >= HALF) |-> (rdata_o == '0)); // R4

endmodule

// File: tb/rng_ctl_unit_tb_top.sv
module rng_ctl_unit_tb_top;
    import rngc_pkg::*;

    localparam int SEEDC = 6;
    localparam int TICK  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr_i = '0;
    logic        we_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] entropy_i = 32'h1234_5678;
    logic [31:0] rdata_o;
    logic        irq_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rng_ctl_unit #(
        .SEED_CYCLES (SEEDC),
        .TICK_CYCLES (TICK)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .we_i      (we_i),
        .wdata_i   (wdata_i),
        .entropy_i (entropy_i),
        .rdata_o   (rdata_o),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic        we;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h04, 32'h0,          32'h0000_0008, 8'd1},  // R1 status
        '{1'b0, 8'h08, 32'h0,          32'h0000_0008, 8'd1},  // R1 mode
        '{1'b0, 8'h10, 32'h0,          32'h0000_0000, 8'd1},  // R1 enable
        '{1'b0, 8'h14, 32'h0,          32'h0000_0000, 8'd1},  // R1 pending
        '{1'b1, 8'h08, 32'hFFFF_FFFF,  32'h0,         8'd13},
        '{1'b0, 8'h08, 32'h0,          32'h0000_0008, 8'd13}, // R13 mode keeps bit 3
        '{1'b1, 8'h08, 32'h0,          32'h0,         8'd4},
        '{1'b0, 8'h04, 32'h0,          32'h0000_0000, 8'd4},  // R4 status mirrors mode
        '{1'b1, 8'h08, 32'h8,          32'h0,         8'd4},
        '{1'b1, 8'h10, 32'hFFFF_FFFF,  32'h0,         8'd13},
        '{1'b0, 8'h10, 32'h0,          32'h8000_0013, 8'd13}, // R13 enable mask
        '{1'b1, 8'h10, 32'h0,          32'h0,         8'd13},
        '{1'b1, 8'h0C, 32'hFFFF_FFFF,  32'h0,         8'd13},
        '{1'b0, 8'h0C, 32'h0,          32'h00FF_0104, 8'd13}, // R13 aux fields
        '{1'b1, 8'h60, 32'hABCD_1234,  32'h0,         8'd13},
        '{1'b0, 8'h60, 32'h0,          32'h0000_1234, 8'd13}, // R13 reload low half
        '{1'b1, 8'h60, 32'h0,          32'h0,         8'd13},
        '{1'b1, 8'h00, 32'h0,          32'h0,         8'd13},
        '{1'b0, 8'h04, 32'h0,          32'h0000_0008, 8'd13}, // R13 no-op command
        '{1'b1, 8'h00, 32'h7,          32'h0,         8'd13},
        '{1'b0, 8'h00, 32'h0,          32'h0000_0000, 8'd13}, // R13 command reads 0
        '{1'b1, 8'h00, 32'h1,          32'h0,         8'd6},
        '{1'b0, 8'h04, 32'h0,          32'h0000_0008, 8'd6},  // R6 gen before seed
        '{1'b0, 8'h14, 32'h0,          32'h0000_0000, 8'd6}   // R6 no ready event
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i = a; we_i = 1'b1; wdata_i = d;
        @(negedge clk);
        we_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr_i = a; we_i = 1'b0;
        #1 d = rdata_o;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        addr_i = a;
        #1 d = rdata_o;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        addr_i = OFF_STAT;
        do begin
            @(negedge clk);
            #1 n++;
        end while (((rdata_o & 32'hC000_0000) != 0) && n < 2000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, w0a;
        int n;
        bit found;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) wr(VECS[i].a, VECS[i].d);
            else begin
                rd(VECS[i].a, v);
                chk($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
            end
        end

        // R2 commanded reseed
        wr(OFF_CMD, CMD_RESEED);
        peek(OFF_STAT, v); chk("R2 seeding flag", v, 32'h8000_0008);
        wait_idle(n);      chk("R2 seeding length", n, SEEDC);
        rd(OFF_STAT, v);   chk("R2 seeded flag", v, 32'h0000_0208);
        rd(OFF_IPEND, v);  chk("R2 seed done event", v, 32'h2);

        // R7 write-one-to-clear
        wr(OFF_IPEND, 32'h0); rd(OFF_IPEND, v); chk("R7 zero write keeps", v, 32'h2);
        wr(OFF_IPEND, 32'h2); rd(OFF_IPEND, v); chk("R7 one write clears", v, 32'h0);

        // R3 wide generation
        wr(OFF_CMD, CMD_GENERATE);
        peek(OFF_STAT, v); chk("R3 generating flag", v, 32'h4000_0208);
        wait_idle(n);      chk("R3 wide length", n, 8);
        rd(OFF_IPEND, v);  chk("R3 ready event", v, 32'h1);
        for (int i = 0; i < 8; i++) begin
            rd(OFF_WORD0 + 8'(4 * i), v);
            chk($sformatf("R3 word %0d nonzero", i), {31'b0, v != 0}, 32'h1);
        end
        rd(OFF_WORD0, w0a);
        wr(OFF_CMD, CMD_GENERATE);
        wait_idle(n);
        rd(OFF_WORD0, v);  chk("R3 new value differs", {31'b0, v != w0a}, 32'h1);

        // R8 interrupt gating (ready pending)
        wr(OFF_IEN, 32'h0);         #1 chk("R8 all disabled", {31'b0, irq_o}, 32'h0);
        wr(OFF_IEN, 32'h1);         #1 chk("R8 no global", {31'b0, irq_o}, 32'h0);
        wr(OFF_IEN, 32'h8000_0001); #1 chk("R8 enabled", {31'b0, irq_o}, 32'h1);
        wr(OFF_IEN, 32'h8000_0002); #1 chk("R8 other source", {31'b0, irq_o}, 32'h0);
        wr(OFF_IEN, 32'h8000_0001);
        wr(OFF_IPEND, 32'h1);       #1 chk("R8 cleared drops irq", {31'b0, irq_o}, 32'h0);
        wr(OFF_IEN, 32'h0);

        // R4 narrow mode
        wr(OFF_MODE, 32'h0);
        wr(OFF_CMD, CMD_GENERATE);
        peek(OFF_STAT, v); chk("R4 status narrow", v, 32'h4000_0200);
        wait_idle(n);      chk("R4 narrow length", n, 4);
        for (int i = 0; i < 8; i++) begin
            rd(OFF_WORD0 + 8'(4 * i), v);
            chk($sformatf("R4 word %0d", i), {31'b0, v != 0}, (i < 4) ? 32'h1 : 32'h0);
        end
        wr(OFF_MODE, 32'h8);

        // R5 commands and mode writes while busy
        wr(OFF_IPEND, 32'h13);
        wr(OFF_CMD, CMD_RESEED);
        wr(OFF_CMD, CMD_GENERATE);
        wr(OFF_MODE, 32'h0);
        wait_idle(n);
        @(negedge clk);
        peek(OFF_STAT, v); chk("R5 no gen, mode kept", v, 32'h0000_0208);
        rd(OFF_IPEND, v);  chk("R5 no ready event", v, 32'h2);

        // R10 request counter
        wr(OFF_IPEND, 32'h13);
        wr(OFF_REQRLD, 32'd2);
        wr(OFF_CMD, CMD_GENERATE); wait_idle(n);
        @(negedge clk); peek(OFF_STAT, v); chk("R10 no reseed after 1", v, 32'h0000_0208);
        wr(OFF_CMD, CMD_GENERATE); wait_idle(n);
        @(negedge clk); peek(OFF_STAT, v); chk("R10 reseed after 2", v, 32'h8000_0208);
        wait_idle(n);
        rd(OFF_IPEND, v);  chk("R10 seed done", v, 32'h3);
        wr(OFF_REQRLD, 32'd0);

        // R12 request counter disabled
        wr(OFF_IPEND, 32'h13);
        for (int i = 0; i < 3; i++) begin
            wr(OFF_CMD, CMD_GENERATE); wait_idle(n);
        end
        repeat (3) @(negedge clk);
        rd(OFF_IPEND, v);  chk("R12 counter off", v, 32'h1);

        // R11 age timer
        wr(OFF_IPEND, 32'h13);
        wr(OFF_AGERLD, 32'd3);
        found = 1'b0;
        addr_i = OFF_STAT;
        for (int i = 0; i < 40 && !found; i++) begin
            @(negedge clk);
            #1 if (rdata_o[STB_SEEDBSY]) found = 1'b1;
        end
        chk("R11 timer reseed", {31'b0, found}, 32'h1);
        wr(OFF_AGERLD, 32'd0);
        wait_idle(n);
        rd(OFF_IPEND, v);  chk("R11 seed done", v, 32'h2);

        // R12 timer disabled
        wr(OFF_IPEND, 32'h13);
        repeat (60) @(negedge clk);
        rd(OFF_IPEND, v);  chk("R12 timer off", v, 32'h0);

        // R9 lockup on zero state
        entropy_i = 32'h0;
        wr(OFF_CMD, CMD_RESEED); wait_idle(n);
        rd(OFF_IPEND, v);  chk("R9 lockup on load", v, 32'h12);
        wr(OFF_CMD, CMD_GENERATE); wait_idle(n);
        rd(OFF_WORD0, v);  chk("R9 zero output", v, 32'h0);
        entropy_i = 32'h1234_5678;
        wr(OFF_CMD, CMD_RESEED); wait_idle(n);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule